// File: doc/BRIEF.md
# Destination Next-Hop Cache

This block is a small fully associative cache that maps an exact 32-bit IPv4 destination address to two output ports, a preferred one and a fallback one. Every clock cycle it can take a lookup. It compares the address against every valid entry in parallel and, one cycle later, reports a hit or a miss together with both ports.

After a miss, an external full-table engine supplies the missing address and its two ports on a fill port. The cache refuses some fills. It never stores a multicast destination, the router's own address, or a route whose ports include a link that this fast path does not serve. A fill for an address that is already present rewrites that entry in place. A fill for a new address takes a victim entry. A build-time parameter picks how the victim is chosen: in oldest-first order, or pseudo-randomly. A flush input invalidates the whole cache in one cycle.

Top module: `dest_route_cache`

## Requirements
- R1: While reset is held and after it is released, `rsp_valid` is 0, and every entry starts invalid, so the first lookup of any address misses.
- R2: Every cycle with `lk_valid` high yields exactly one response with `rsp_valid` high on the following cycle. A cycle with `lk_valid` low yields `rsp_valid` low on the following cycle. Lookups may arrive back to back.
- R3: On a hit, `rsp_hit` is 1 and `rsp_pri`/`rsp_alt` carry the ports stored for that address. On a miss, or when no response is valid, `rsp_hit`, `rsp_pri` and `rsp_alt` are all 0.
- R4: An accepted fill is visible to lookups from the next cycle. A lookup in the same cycle as the fill sees the contents from before the fill.
- R5: A fill for an address already held in a valid entry replaces that entry's two ports and allocates no new entry. No address is ever held twice.
- R6: With `RANDOM_REPL`=0, new addresses go to entries 0, 1, 2, ... in turn. The pointer wraps from `ENTRIES`-1 back to 0, so once the cache is full the oldest allocation is overwritten.
- R7: With `RANDOM_REPL`=1, the victim is the 16-bit register value modulo `ENTRIES`. The register is seeded to 16'hACE1. On each allocating fill it shifts left, taking bit15^bit13^bit12^bit10 into bit 0.
- R8: A fill whose address has bits [31:28] equal to 4'b1110 (multicast) is refused and changes nothing.
- R9: A fill whose address equals `LOCAL_ADDR` is refused and changes nothing.
- R10: A fill is refused and changes nothing (an existing entry for the same address keeps its old ports) when bit p of `SERVED_MASK` is 0 for either its preferred or its fallback port p.
- R11: `flush` invalidates every entry at the clock edge. It resets the oldest-first pointer to 0 and reseeds the random register to 16'hACE1. A fill in the same cycle is dropped. A lookup in the same cycle sees the contents from before the flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | 32 | Destination address to look up |
| rsp_valid | output | 1 | Response for the previous cycle's lookup |
| rsp_hit | output | 1 | Address was found |
| rsp_pri | output | PORT_W | Preferred output port on a hit, else 0 |
| rsp_alt | output | PORT_W | Fallback output port on a hit, else 0 |
| fill_valid | input | 1 | Fill offered this cycle |
| fill_addr | input | 32 | Address being filled |
| fill_pri | input | PORT_W | Preferred port for the filled address |
| fill_alt | input | PORT_W | Fallback port for the filled address |
| flush | input | 1 | Invalidate all entries |

## Verification
The assertions take no handshake for granted, because the block has no back-pressure: any lookup, fill and flush may arrive together in any cycle. The in-place update property assumes that stored addresses come only through the fill port, where duplicates are merged. The stimulus therefore exercises duplicates only by refilling an existing address, and it places lookups, fills and flushes in the same cycle to reach the ordering rules. Both replacement variants receive identical traffic, and a behavioural model predicts every response of each one.

// File: rtl/dest_route_cache_pkg.sv
// Shared constants and helpers for the destination next-hop cache.
// Assumes IPv4 addressing: 32-bit destinations, multicast in class D.
package dest_route_cache_pkg;
    localparam int ADDR_W = 32;
    localparam logic [3:0] MCAST_TOP = 4'b1110;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // True when the destination lies in the multicast range.
    function automatic logic is_multicast(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: 4] == MCAST_TOP;
    endfunction
endpackage

// File: rtl/rc_match.sv
// Parallel exact-match comparator across all cache entries.
// Assumes the fill logic never stores an address twice, so the
// match vector is at most one-hot.
module rc_match #(
    parameter int ENTRIES = 100,
    parameter int ADDR_W  = 32
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tags,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match,
    output logic                           hit
);
    // One comparator per entry, gated by the entry's valid bit.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = valid[i] && (tags[i] == key);
    end

    // Any entry matching means a hit.
    assign hit = |match;
endmodule

// File: rtl/rc_admit.sv
// Fill admission filter: refuses routes that must never be cached.
// Assumes port numbers index SERVED_MASK; ports beyond NUM_PORTS count
// as unserved.
module rc_admit
    import dest_route_cache_pkg::*;
#(
    parameter int                   NUM_PORTS   = 16,
    parameter int                   PORT_W      = 4,
    parameter logic [ADDR_W-1:0]    LOCAL_ADDR  = 32'h0A00_0001,
    parameter logic [NUM_PORTS-1:0] SERVED_MASK = '1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] pri,
    input  logic [PORT_W-1:0] alt,
    output logic              refuse
);
    localparam int PORT_SPAN = 1 << PORT_W;
    localparam logic [PORT_SPAN-1:0] MASK_EXT = PORT_SPAN'(SERVED_MASK);

    // Refuse multicast, local, or any route using an unserved link.
    always_comb begin
        refuse = is_multicast(addr)
              || (addr == LOCAL_ADDR)
              || !MASK_EXT[pri]
              || !MASK_EXT[alt];
    end
endmodule

// File: rtl/rc_victim.sv
// Victim selector for allocating fills: oldest-first pointer or a
// 16-bit LFSR reduced modulo ENTRIES, chosen by RANDOM_REPL.
// Assumes advance and restart are never both high in a cycle.
module rc_victim
    import dest_route_cache_pkg::*;
#(
    parameter int ENTRIES     = 100,
    parameter bit RANDOM_REPL = 1'b0,
    localparam int IDX_W      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    input  logic             restart,
    output logic [IDX_W-1:0] idx
);
    if (RANDOM_REPL) begin : g_rand
        logic [15:0] lfsr_q;

        // Step the LFSR on each allocation; reseed on reset or flush.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                lfsr_q <= LFSR_SEED;
            end else if (advance) begin
                lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
            end
        end

        // Reduce the current LFSR state into the entry range.
        assign idx = IDX_W'(lfsr_q % 16'(ENTRIES));
    end else begin : g_fifo
        logic [IDX_W-1:0] ptr_q;

        // Step the oldest-first pointer, wrapping at ENTRIES.
        always_ff @(posedge clk) begin
            if (!rst_n || restart) begin
                ptr_q <= '0;
            end else if (advance) begin
                ptr_q <= (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end

        assign idx = ptr_q;
    end
endmodule

// File: rtl/dest_route_cache.sv
// Destination next-hop cache: exact-match lookup of an IPv4 address
// returning a preferred and a fallback port, filled from an external
// full-table engine. Assumes lookups may arrive every cycle; a response
// appears one cycle after its request. Same-cycle lookups see contents
// from before any fill or flush in that cycle.
module dest_route_cache
    import dest_route_cache_pkg::*;
#(
    parameter int                   ENTRIES     = 100,
    parameter int                   NUM_PORTS   = 16,
    parameter bit                   RANDOM_REPL = 1'b0,
    parameter logic [ADDR_W-1:0]    LOCAL_ADDR  = 32'h0A00_0001,
    parameter logic [NUM_PORTS-1:0] SERVED_MASK = '1,
    localparam int                  PORT_W      = $clog2(NUM_PORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PORT_W-1:0] rsp_pri,
    output logic [PORT_W-1:0] rsp_alt,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [PORT_W-1:0] fill_pri,
    input  logic [PORT_W-1:0] fill_alt,
    input  logic              flush
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0] addr_q;
    logic [ENTRIES-1:0][PORT_W-1:0] pri_q;
    logic [ENTRIES-1:0][PORT_W-1:0] alt_q;

    logic [ENTRIES-1:0] lk_match;
    logic               lk_hit;
    logic [ENTRIES-1:0] fl_match;
    logic               fl_hit;
    logic               fill_refuse;
    logic               fill_accept;
    logic               fill_alloc;
    logic [IDX_W-1:0]   victim_idx;
    logic [ENTRIES-1:0] wr_en;
    logic [PORT_W-1:0]  sel_pri;
    logic [PORT_W-1:0]  sel_alt;

    rc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lk_match (
        .valid (valid_q),
        .tags  (addr_q),
        .key   (lk_addr),
        .match (lk_match),
        .hit   (lk_hit)
    );

    rc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_fill_match (
        .valid (valid_q),
        .tags  (addr_q),
        .key   (fill_addr),
        .match (fl_match),
        .hit   (fl_hit)
    );

    rc_admit #(
        .NUM_PORTS   (NUM_PORTS),
        .PORT_W      (PORT_W),
        .LOCAL_ADDR  (LOCAL_ADDR),
        .SERVED_MASK (SERVED_MASK)
    ) u_admit (
        .addr   (fill_addr),
        .pri    (fill_pri),
        .alt    (fill_alt),
        .refuse (fill_refuse)
    );

    rc_victim #(.ENTRIES(ENTRIES), .RANDOM_REPL(RANDOM_REPL)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_alloc),
        .restart (flush),
        .idx     (victim_idx)
    );

    // Classify the fill: flush wins, refused fills do nothing.
    always_comb begin
        fill_accept = fill_valid && !flush && !fill_refuse;
        fill_alloc  = fill_accept && !fl_hit;
    end

    // Entry write enables: the existing match, otherwise the victim.
    for (genvar i = 0; i < ENTRIES; i++) begin : g_we
        assign wr_en[i] = fill_accept &&
                          (fl_hit ? fl_match[i] : (victim_idx == IDX_W'(i)));
    end

    // Select the hit entry's ports with an AND-OR tree over the one-hot match.
    always_comb begin
        sel_pri = '0;
        sel_alt = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) begin
                sel_pri = sel_pri | pri_q[i];
                sel_alt = sel_alt | alt_q[i];
            end
        end
    end

    // Entry storage: flush clears the valid bits, fills write one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            addr_q  <= '0;
            pri_q   <= '0;
            alt_q   <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (wr_en[i]) begin
                    valid_q[i] <= 1'b1;
                    addr_q[i]  <= fill_addr;
                    pri_q[i]   <= fill_pri;
                    alt_q[i]   <= fill_alt;
                end
            end
        end
    end

    // Register the lookup response; ports read as zero unless it is a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pri   <= '0;
            rsp_alt   <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_hit;
            rsp_pri   <= (lk_valid && lk_hit) ? sel_pri : '0;
            rsp_alt   <= (lk_valid && lk_hit) ? sel_alt : '0;
        end
    end
endmodule

// File: rtl/dest_route_cache_chk.sv
// Property checker for dest_route_cache, attached through bind.
// Assumes synchronous active-low reset; observes ports and internal state.
module dest_route_cache_chk #(
    parameter int ENTRIES = 100,
    parameter int PORT_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [PORT_W-1:0]  rsp_pri,
    input logic [PORT_W-1:0]  rsp_alt,
    input logic               fill_valid,
    input logic               fill_refuse,
    input logic               flush,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_match,
    input logic [IDX_W-1:0]   victim_idx
);
    a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);

    a_r3_miss_ports_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_pri == '0 && rsp_alt == '0));

    a_r3_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r6_victim_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        victim_idx < IDX_W'(ENTRIES));

    a_r8_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_refuse && !flush) |=> $stable(valid_q));

    a_r11_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));
endmodule

bind dest_route_cache dest_route_cache_chk #(.ENTRIES(ENTRIES), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_valid    (lk_valid),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_pri     (rsp_pri),
    .rsp_alt     (rsp_alt),
    .fill_valid  (fill_valid),
    .fill_refuse (fill_refuse),
    .flush       (flush),
    .valid_q     (valid_q),
    .lk_match    (lk_match),
    .victim_idx  (victim_idx)
);

// File: tb/test_dest_route_cache.sv
`timescale 1ns/1ps
// Bench: both replacement variants get the same traffic; a behavioural
// model of each predicts every response, compared on every clock.
module test_dest_route_cache;
    localparam int E = 100;
    localparam logic [31:0] LOCAL = 32'h0A00_0001;
    localparam logic [31:0] BASE  = 32'h0B00_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [3:0] fill_pri = '0;
    logic [3:0] fill_alt = '0;
    logic flush = 1'b0;

    logic rv [2];
    logic rh [2];
    logic [3:0] rp [2];
    logic [3:0] ra [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Behavioural model state, index 0 = oldest-first, 1 = random
    bit          mv  [2][E];
    logic [31:0] ma  [2][E];
    int          mp  [2][E];
    int          mal [2][E];
    int          mptr [2];
    logic [15:0] mlf [2];
    bit          ev [2];
    bit          eh [2];
    int          ep [2];
    int          ea [2];

    always #2.5 clk = ~clk;

    dest_route_cache #(.ENTRIES(E), .NUM_PORTS(16), .RANDOM_REPL(1'b0),
                       .LOCAL_ADDR(LOCAL), .SERVED_MASK(16'h00FF)) i_dest_route_cache (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rv[0]), .rsp_hit(rh[0]), .rsp_pri(rp[0]), .rsp_alt(ra[0]),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_pri(fill_pri),
        .fill_alt(fill_alt), .flush(flush));

    dest_route_cache #(.ENTRIES(E), .NUM_PORTS(16), .RANDOM_REPL(1'b1),
                       .LOCAL_ADDR(LOCAL), .SERVED_MASK(16'h00FF)) i_dest_route_cache_rnd (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rv[1]), .rsp_hit(rh[1]), .rsp_pri(rp[1]), .rsp_alt(ra[1]),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_pri(fill_pri),
        .fill_alt(fill_alt), .flush(flush));

    function automatic bit refused(input logic [31:0] a, input int p, input int al);
        return (a[31:28] == 4'b1110) || (a == LOCAL) || (p >= 8) || (al >= 8);
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < E; i++) mv[k][i] = 1'b0;
            mptr[k] = 0;
            mlf[k] = 16'hACE1;
        end
    endtask

    // One cycle: drive at negedge, predict, update model, compare next negedge.
    task automatic step(input bit lv, input logic [31:0] la, input bit fv,
                        input logic [31:0] fa, input int fp, input int fal,
                        input bit fl, input string tag);
        lk_valid = lv; lk_addr = la;
        fill_valid = fv; fill_addr = fa; fill_pri = 4'(fp); fill_alt = 4'(fal);
        flush = fl;
        for (int k = 0; k < 2; k++) begin
            ev[k] = lv; eh[k] = 1'b0; ep[k] = 0; ea[k] = 0;
            if (lv) begin
                for (int i = 0; i < E; i++) begin
                    if (mv[k][i] && ma[k][i] == la) begin
                        eh[k] = 1'b1; ep[k] = mp[k][i]; ea[k] = mal[k][i];
                    end
                end
            end
            if (fl) begin
                for (int i = 0; i < E; i++) mv[k][i] = 1'b0;
                mptr[k] = 0;
                mlf[k] = 16'hACE1;
            end else if (fv && !refused(fa, fp, fal)) begin
                int slot = -1;
                for (int i = 0; i < E; i++) if (mv[k][i] && ma[k][i] == fa) slot = i;
                if (slot < 0) begin
                    if (k == 0) begin
                        slot = mptr[k];
                        mptr[k] = (mptr[k] == E - 1) ? 0 : mptr[k] + 1;
                    end else begin
                        slot = int'(mlf[k]) % E;
                        mlf[k] = {mlf[k][14:0], mlf[k][15] ^ mlf[k][13] ^ mlf[k][12] ^ mlf[k][10]};
                    end
                end
                mv[k][slot] = 1'b1; ma[k][slot] = fa; mp[k][slot] = fp; mal[k][slot] = fal;
            end
        end
        @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (rv[k] !== ev[k] || rh[k] !== eh[k] || int'(rp[k]) != ep[k] || int'(ra[k]) != ea[k]) begin
                errors++;
                $display("FAIL %s inst%0d addr=%h actual v=%b h=%b p=%0d a=%0d expected v=%b h=%b p=%0d a=%0d",
                         tag, k, la, rv[k], rh[k], rp[k], ra[k], ev[k], eh[k], ep[k], ea[k]);
            end
        end
    endtask

    task automatic look(input logic [31:0] a, input string tag);
        step(1'b1, a, 1'b0, '0, 0, 0, 1'b0, tag);
    endtask

    task automatic fill(input logic [31:0] a, input int p, input int al, input string tag);
        step(1'b0, '0, 1'b1, a, p, al, 1'b0, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            checks++;
            if (rv[k] !== 1'b0) begin
                errors++;
                $display("FAIL R1 inst%0d rsp_valid in reset actual %b expected 0", k, rv[k]);
            end
        end
        rst_n = 1'b1;
        step(1'b0, '0, 1'b0, '0, 0, 0, 1'b0, "R1");
        look(BASE, "R1");
        // Lookup and fill of the same address in one cycle: old contents seen
        step(1'b1, BASE, 1'b1, BASE, 3, 5, 1'b0, "R4");
        look(BASE, "R3");
        look(BASE + 7, "R3");
        step(1'b0, BASE, 1'b0, '0, 0, 0, 1'b0, "R2");
        // Refill in place
        fill(BASE, 6, 1, "R5");
        look(BASE, "R5");
        // Refusals
        fill(32'hE000_0005, 1, 2, "R8");  look(32'hE000_0005, "R8");
        fill(32'hEFFF_FFFF, 1, 2, "R8");  look(32'hEFFF_FFFF, "R8");
        fill(LOCAL, 2, 3, "R9");          look(LOCAL, "R9");
        fill(BASE + 900, 9, 2, "R10");    look(BASE + 900, "R10");
        fill(BASE + 901, 2, 12, "R10");   look(BASE + 901, "R10");
        fill(BASE, 2, 15, "R10");         look(BASE, "R10");
        // Fill to capacity, then one more evicts the oldest
        for (int n = 1; n < E; n++) fill(BASE + n, n % 8, (n + 3) % 8, "R6");
        look(BASE, "R6");
        fill(BASE + E, 4, 4, "R6");
        look(BASE, "R6");
        look(BASE + 1, "R6");
        look(BASE + E, "R6");
        // Interleaved fills and back-to-back lookups
        for (int n = 200; n < 260; n++)
            step(1'b1, BASE + n - 100, 1'b1, BASE + n, n % 8, (n + 5) % 8, 1'b0, "R7");
        for (int n = 0; n < 260; n++) look(BASE + n, "R7");
        // Flush with same-cycle lookup and fill
        step(1'b1, BASE + E, 1'b1, BASE + 500, 1, 1, 1'b1, "R11");
        look(BASE + 500, "R11");
        look(BASE + E, "R11");
        fill(BASE + 600, 2, 3, "R11");
        fill(BASE + 601, 4, 5, "R11");
        look(BASE + 600, "R11");
        look(BASE + 601, "R11");
        for (int n = 0; n < 130; n++) fill(BASE + 1000 + n * 3, n % 8, (n + 1) % 8, "R7");
        for (int n = 0; n < 130; n++) look(BASE + 1000 + n * 3, "R7");
        look(BASE + 600, "R6");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule